// File: doc/BRIEF.md
# Dual-Tone Alert Detector

This block watches a stream of signed audio samples, taken at 8000 samples per second, for an alerting signal made of two tones sent together, one near 2130 Hz and one near 2750 Hz. Each tone has its own Goertzel filter, and both filters run over fixed blocks of 96 samples. At the end of each block the two tone energies are compared with a minimum level and with each other. The result is a steering flag that is high when both tones were present in that block.

The steering flag drives a saturating up/down counter that takes the place of a capacitor-and-resistor delay. The counter moves by one step per block. The qualified-detect output sets when the counter reaches its upper threshold. It clears only when the counter has drained back to zero, so a short dropout or an out-of-range block does not end a detection that is already running. A new detection pulls an active-low interrupt line low, and the line stays low until the host pulses an acknowledge input.

Top module: `dual_tone_alert`

## Requirements
- R1: The steering flag changes only at the end of a 96-sample block. The new value is visible two clock cycles after the block's last sample is accepted, and it describes that block alone.
- R2: A block that carries both tones at equal, adequate amplitude sets the steering flag to 1.
- R3: A block that carries only one tone, or silence, sets the steering flag to 0.
- R4: When both tones are above the minimum energy, the steering flag is 1 only if neither tone's energy exceeds four times the other's (6 dB). A pair with a larger spread gives 0.
- R5: The qualification counter rises by 1 after each block with steering 1 and falls by 1 after each block with steering 0. It saturates at 0 and at 7.
- R6: The qualified-detect output sets in the block where the counter reaches 5.
- R7: Once set, the qualified-detect output stays high until the counter reaches 0, including across blocks with steering 0.
- R8: The interrupt output goes low in the cycle after qualified-detect rises. It returns high only after a cycle with the acknowledge input high, and a rise of qualified-detect takes precedence over an acknowledge in the same cycle.
- R9: After reset, the steering flag is 0, qualified-detect is 0, the interrupt output is 1 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | Marks a valid sample on smp_data for this cycle |
| smp_data | input | 16 | Signed two's-complement audio sample |
| int_ack | input | 1 | Host acknowledge; high for one cycle releases the interrupt |
| tone_steer | output | 1 | Early steering: both tones seen in the last block |
| tone_qual | output | 1 | Qualified dual-tone detect |
| alert_int_n | output | 1 | Active-low interrupt, latched on a new detection |

## Verification
A filter state that is wrong, or a sample counter that has drifted, shows up at tone_steer at the next block boundary, about 96 samples later. It shows either as a wrong value or as a change outside the two-cycle slot after a block's last sample. A counter fault is slower to surface. It shows at tone_qual as a set that comes one block early or late, as a clear during a short dropout, or as a clear that comes too soon after saturation, and so it may take up to eight blocks to appear. The bench runs sequences through each of these: a ramp to the threshold, a one-block dropout, a saturating run, and a full drain. It also holds alert_int_n against acknowledge pulses.

// File: rtl/dta_pkg.sv
package dta_pkg;
  localparam int SAMP_W    = 16;
  localparam int ACC_W     = 32;
  localparam int PWR_W     = 64;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [PWR_W-1:0]  pwr_t;
  typedef logic signed [COEF_W-1:0] coef_t;
endpackage

// File: rtl/dta_rst_sync.sv
module dta_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/dta_goertzel.sv
module dta_goertzel
  import dta_pkg::*;
#(
  parameter coef_t COEF = coef_t'(-3340)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  in_valid,
  input  samp_t in_sample,
  output pwr_t  power
);
  acc_t s1_q, s2_q, s1_d, s2_d;
  acc_t fb, s0;
  pwr_t prod, pw_raw;

  always_comb begin
    prod = pwr_t'(s1_q) * pwr_t'(COEF);
    fb   = acc_t'(prod >>> COEF_FRAC);
    s0   = acc_t'(in_sample) + fb - s2_q;
    s1_d = s1_q;
    s2_d = s2_q;
    if (clear) begin
      s1_d = in_valid ? acc_t'(in_sample) : '0;
      s2_d = '0;
    end else if (in_valid) begin
      s1_d = s0;
      s2_d = s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (clear || in_valid) begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  always_comb begin
    pw_raw = pwr_t'(s1_q) * pwr_t'(s1_q) + pwr_t'(s2_q) * pwr_t'(s2_q)
           - pwr_t'(fb) * pwr_t'(s2_q);
    power  = pw_raw[PWR_W-1] ? '0 : pw_raw;
  end
endmodule

// File: rtl/dta_judge.sv
module dta_judge
  import dta_pkg::*;
#(
  parameter pwr_t E_MIN = pwr_t'(64'd1073741824)
) (
  input  pwr_t pwr_lo,
  input  pwr_t pwr_hi,
  output logic both
);
  logic lo_ok, hi_ok, balanced;

  always_comb begin
    lo_ok    = pwr_lo > E_MIN;
    hi_ok    = pwr_hi > E_MIN;
    balanced = ((pwr_lo <<< 2) >= pwr_hi) && ((pwr_hi <<< 2) >= pwr_lo);
    both     = lo_ok && hi_ok && balanced;
  end
endmodule

// File: rtl/dta_qual_timer.sv
module dta_qual_timer #(
  parameter int TMAX = 7,
  parameter int QTH  = 5,
  localparam int CW  = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          steer,
  output logic [CW-1:0] cnt,
  output logic          qual,
  output logic          qual_rise
);
  logic [CW-1:0] cnt_d;
  logic          qual_d;

  always_comb begin
    cnt_d  = cnt;
    qual_d = qual;
    if (tick) begin
      if (steer) cnt_d = (cnt == CW'(TMAX)) ? cnt : cnt + 1'b1;
      else       cnt_d = (cnt == '0) ? cnt : cnt - 1'b1;
      if (cnt_d >= CW'(QTH))  qual_d = 1'b1;
      else if (cnt_d == '0)   qual_d = 1'b0;
    end
    qual_rise = qual_d && !qual;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (tick) begin
      cnt  <= cnt_d;
      qual <= qual_d;
    end
  end
endmodule

// File: rtl/dual_tone_alert.sv
module dual_tone_alert
  import dta_pkg::*;
#(
  parameter int    BLOCK_N = 96,
  parameter coef_t COEF_LO = coef_t'(-3340),
  parameter coef_t COEF_HI = coef_t'(-18205),
  parameter pwr_t  E_MIN   = pwr_t'(64'd1073741824),
  parameter int    TMAX    = 7,
  parameter int    QTH     = 5,
  localparam int   SCW     = $clog2(BLOCK_N),
  localparam int   CW      = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [SAMP_W-1:0] smp_data,
  input  logic              int_ack,
  output logic              tone_steer,
  output logic              tone_qual,
  output logic              alert_int_n
);
  logic           rst_sn;
  logic [SCW-1:0] scnt_q;
  logic           blk_done;
  logic           last_smp;
  pwr_t           pwr [2];
  logic           both;
  logic [CW-1:0]  cnt;
  logic           qual_rise;
  logic           int_n_d;

  dta_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign last_smp = smp_valid && (scnt_q == SCW'(BLOCK_N - 1));

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scnt_q   <= '0;
      blk_done <= 1'b0;
    end else begin
      blk_done <= last_smp;
      if (smp_valid) scnt_q <= last_smp ? '0 : scnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_tone
    dta_goertzel #(.COEF(g == 0 ? COEF_LO : COEF_HI)) u_filt (
      .clk      (clk),
      .rst_n    (rst_sn),
      .clear    (blk_done),
      .in_valid (smp_valid),
      .in_sample(samp_t'(smp_data)),
      .power    (pwr[g])
    );
  end

  dta_judge #(.E_MIN(E_MIN)) u_judge (
    .pwr_lo(pwr[0]),
    .pwr_hi(pwr[1]),
    .both  (both)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       tone_steer <= 1'b0;
    else if (blk_done) tone_steer <= both;
  end

  dta_qual_timer #(.TMAX(TMAX), .QTH(QTH)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sn),
    .tick     (blk_done),
    .steer    (both),
    .cnt      (cnt),
    .qual     (tone_qual),
    .qual_rise(qual_rise)
  );

  always_comb begin
    int_n_d = alert_int_n;
    if (qual_rise)    int_n_d = 1'b0;
    else if (int_ack) int_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) alert_int_n <= 1'b1;
    else         alert_int_n <= int_n_d;
  end
endmodule

// File: rtl/dta_checker.sv
module dta_checker #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_done,
  input logic          tone_steer,
  input logic          tone_qual,
  input logic          alert_int_n,
  input logic          int_ack,
  input logic [CW-1:0] cnt
);
  AST_STEER_AT_BLOCK_END: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |=> $stable(tone_steer)); // R1
  AST_CNT_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1) || CW'(cnt + 1) == $past(cnt))); // R5
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_done |=> $stable(cnt)); // R5
  AST_QUAL_RISE_STEER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_qual) |-> tone_steer); // R6
  AST_QUAL_FALL_NOSTEER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tone_qual) |-> (!tone_steer && cnt == '0)); // R7
  AST_INT_ON_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_qual) |=> !alert_int_n); // R8
  AST_INT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_int_n && !int_ack) |=> !alert_int_n); // R8
endmodule

bind dual_tone_alert dta_checker #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_done   (blk_done),
  .tone_steer (tone_steer),
  .tone_qual  (tone_qual),
  .alert_int_n(alert_int_n),
  .int_ack    (int_ack),
  .cnt        (cnt)
);

// File: tb/tb_dual_tone_alert.sv
module tb_dual_tone_alert;
  localparam int    N    = 96;
  localparam int    TMAX = 7;
  localparam int    QTH  = 5;
  localparam real   FS   = 8000.0;
  localparam real   TWO_PI = 6.283185307179586;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [15:0] smp_data;
  logic        int_ack;
  logic        tone_steer, tone_qual, alert_int_n;

  dual_tone_alert dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .int_ack(int_ack), .tone_steer(tone_steer), .tone_qual(tone_qual),
    .alert_int_n(alert_int_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit    est;
    bit    qual;
    bit    intn;
    string est_tag;
    string q_tag;
  } exp_t;

  exp_t  sb[$];
  event  blk_ev;
  int    checks = 0;
  int    errors = 0;
  int    n_glob = 0;
  int    m_cnt  = 0;
  bit    m_qual = 0;
  bit    m_intn = 1;

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Driver: updates the requirement model, queues the expectation, plays one block
  task automatic run_block(real aa, real ab, bit exp_est, string etag, string qtag);
    exp_t e;
    bit   was_q;
    was_q = m_qual;
    if (exp_est) m_cnt = (m_cnt == TMAX) ? m_cnt : m_cnt + 1;
    else         m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
    if (m_cnt >= QTH)    m_qual = 1;
    else if (m_cnt == 0) m_qual = 0;
    if (m_qual && !was_q) m_intn = 0;
    e.est = exp_est; e.qual = m_qual; e.intn = m_intn;
    e.est_tag = etag; e.q_tag = qtag;
    sb.push_back(e);
    for (int i = 0; i < N; i++) begin
      real v;
      v = aa * $sin(TWO_PI * 2130.0 * n_glob / FS) + ab * $sin(TWO_PI * 2750.0 * n_glob / FS);
      n_glob++;
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = 16'($rtoi(v));
      @(negedge clk);
      smp_valid = 1'b0;
    end
    @(negedge clk);
    -> blk_ev;
  endtask

  task automatic ack_pulse(bit exp_intn);
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    m_intn = 1;
    chk(alert_int_n == exp_intn, "R8 ack release", alert_int_n, exp_intn);
  endtask

  // Monitor: pops one expectation per finished block
  initial begin
    forever begin
      exp_t e;
      @(blk_ev);
      if (sb.size() == 0) begin
        chk(1'b0, "R1 scoreboard empty", 0, 1);
      end else begin
        e = sb.pop_front();
        chk(tone_steer == e.est, e.est_tag, tone_steer, e.est);
        chk(tone_qual == e.qual, e.q_tag, tone_qual, e.qual);
        chk(alert_int_n == e.intn, "R8 interrupt level", alert_int_n, e.intn);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; int_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(tone_steer == 1'b0, "R9 steer", tone_steer, 0);
    chk(tone_qual == 1'b0, "R9 qual", tone_qual, 0);
    chk(alert_int_n == 1'b1, "R9 int", alert_int_n, 1);

    // R2 ramp toward the threshold, R1 timing of every block
    for (int k = 0; k < 3; k++) run_block(8000.0, 8000.0, 1, "R2 both tones", "R6 below threshold");
    run_block(0.0, 0.0, 0, "R3 silence", "R5 count down");
    for (int k = 0; k < 3; k++) run_block(8000.0, 8000.0, 1, "R2 both tones", "R6 reach threshold");
    // R7 one-block dropout rides through
    run_block(8000.0, 0.0, 0, "R3 low tone only", "R7 hold in dropout");
    ack_pulse(1'b1);
    // R5 saturation at TMAX, R4 loud and mildly uneven pairs still pass
    run_block(14000.0, 14000.0, 1, "R4 loud pair", "R7 held");
    run_block(8000.0, 5000.0, 1, "R4 within 6 dB", "R7 held");
    for (int k = 0; k < 3; k++) run_block(8000.0, 8000.0, 1, "R2 both tones", "R5 saturate");
    // R4 spread beyond 6 dB drains the counter; R7 clear only at zero
    for (int k = 0; k < 6; k++) run_block(8000.0, 2000.0, 0, "R4 spread over 6 dB", "R7 held while draining");
    run_block(0.0, 8000.0, 0, "R3 high tone only", "R7 clear at zero");
    run_block(0.0, 0.0, 0, "R3 silence", "R5 floor at zero");
    chk(alert_int_n == 1'b1, "R8 no new interrupt", alert_int_n, 1);
    // second detection re-arms the interrupt
    for (int k = 0; k < 5; k++) run_block(8000.0, 8000.0, 1, "R2 both tones", "R6 second detect");
    chk(alert_int_n == 1'b0, "R8 second interrupt", alert_int_n, 0);
    ack_pulse(1'b1);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R1 all blocks seen", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule